// File: doc/BRIEF.md
# Up-Counting Compare Timer with Rollover

This block is a general-purpose up-counter with a single output-compare channel and a small word-addressed register file. A selectable source tick, which is either the fast peripheral tick or the slow 32 kHz tick, is divided by a 12-bit prescaler. Each divided tick advances the count by one. A compare flag is raised when the count reaches the compare value. A rollover flag is raised when the count wraps past its all-ones value. A level interrupt combines both flags with their enables.

There are two counting modes. In free-run mode the count passes the compare value and keeps going up to all-ones, then wraps. In restart mode the count returns to zero on the step after it has reached the compare value. An enable-mode bit decides whether a fresh enable clears the count or resumes from the held value. A software-reset bit in the control word returns the timer to a known state.

Top module: `cmp_rollover_timer`

## Requirements
- R1: After hardware reset, the control word, prescaler, status, interrupt enable and count all read as 0, and the compare value reads as all-ones of the count width.
- R2: The word index selects the register: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4 compare, 9 count (read only). Every other index reads 0 and writes to it have no effect. Control bits 15:10 always read 0.
- R3: The prescaler holds 12 bits, and the count advances once per (prescaler+1) source ticks. The division phase starts at zero whenever the timer is enabled.
- R4: Control bits 8:6 select the source. Codes 001 and 010 select the peripheral tick, code 100 selects the slow tick, and every other code stops counting.
- R5: In free-run mode (control bit 9 = 1), status bit 0 is set on the step that makes the count equal to the compare value, and counting continues past it.
- R6: In free-run mode, status bit 5 is set on the step that wraps the count from all-ones to 0.
- R7: In restart mode (control bit 9 = 0), status bit 0 is set when the count reaches the compare value, and the next step returns the count to 0.
- R8: Writing status with 1 in bit 0 or bit 5 clears that flag, and writing 0 leaves it unchanged. A flag event in the same cycle wins over the clear.
- R9: The interrupt-enable register holds 6 bits. The irq output is high exactly when control bit 0 is 1 and (status bit 0 and enable bit 0) or (status bit 5 and enable bit 5).
- R10: When control bit 0 goes from 0 to 1 with bit 1 set, the count is cleared. With bit 1 clear, the count resumes from its held value.
- R11: While control bit 0 is 0, the count does not change.
- R12: In restart mode, a write to the compare register clears the count to 0.
- R13: A control write with bit 15 set stores the written word with bits 0, 2, 3, 4, 15 and 14:10 cleared. It also clears status, prescaler, interrupt enable and count, and sets the compare value to all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| periph_tick | input | 1 | Fast peripheral source tick enable |
| slow_tick | input | 1 | Slow 32 kHz source tick enable |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for reg_addr |
| irq | output | 1 | Level interrupt |

## Verification
The bench drives the count across the all-ones boundary in a narrowed configuration, so a design that raises the rollover flag at the wrong step, or never raises it, shows up in the status word. It walks restart mode through the compare match. An off-by-one in the restart comparison would leave the count one past the compare value or reset it one step early. The prescaler is checked at the tick just before a step and at the tick that causes it, which catches a divider that divides by the prescaler value instead of that value plus one. Separate checks cover clearing with 0 versus 1 in the status bits, enable with and without the clear mode, an unused source code that must freeze the count, and software reset leaving the non-reset control bits intact.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int IDX_CTRL  = 0;
  localparam int IDX_PRESC = 1;
  localparam int IDX_STAT  = 2;
  localparam int IDX_IEN   = 3;
  localparam int IDX_CMP   = 4;
  localparam int IDX_COUNT = 9;

  localparam int CB_EN    = 0;
  localparam int CB_ENCLR = 1;
  localparam int CB_DBG   = 2;
  localparam int CB_WAIT  = 3;
  localparam int CB_DOZE  = 4;
  localparam int CB_SRC_LO = 6;
  localparam int CB_SRC_HI = 8;
  localparam int CB_FREE  = 9;
  localparam int CB_SWRST = 15;

  localparam int SB_CMP = 0;
  localparam int SB_ROV = 5;

  typedef enum logic [2:0] {
    SRC_OFF   = 3'b000,
    SRC_FAST0 = 3'b001,
    SRC_FAST1 = 3'b010,
    SRC_SLOW  = 3'b100
  } src_sel_e;

  function automatic logic pick_tick(input logic [2:0] sel,
                                     input logic fast, input logic slow);
    case (sel)
      SRC_FAST0, SRC_FAST1: pick_tick = fast;
      SRC_SLOW:             pick_tick = slow;
      default:              pick_tick = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/cmpt_rst_sync.sv
module cmpt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cmpt_tick_gen.sv
module cmpt_tick_gen #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             phase_clr_i,
  input  logic [2:0]       src_sel_i,
  input  logic             fast_tick_i,
  input  logic             slow_tick_i,
  input  logic [PRE_W-1:0] presc_i,
  output logic             step_o
);
  import cmpt_pkg::*;

  logic [PRE_W-1:0] div_q, div_d;
  logic             div_en;
  logic             src_tick;
  logic             at_end;

  assign src_tick = pick_tick(src_sel_i, fast_tick_i, slow_tick_i);
  assign at_end   = (div_q == presc_i);

  always_comb begin
    div_en = 1'b0;
    div_d  = div_q;
    if (!run_i || phase_clr_i) begin
      div_en = 1'b1;
      div_d  = '0;
    end else if (src_tick) begin
      div_en = 1'b1;
      div_d  = at_end ? '0 : div_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      div_q <= '0;
    else if (div_en) div_q <= div_d;
  end

  assign step_o = run_i && src_tick && at_end;
endmodule

// File: rtl/cmpt_count_core.sv
module cmpt_count_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic             free_run_i,
  input  logic [CNT_W-1:0] cmp_i,
  output logic [CNT_W-1:0] count_o,
  output logic             hit_cmp_o,
  output logic             hit_rov_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, nxt;
  logic             cnt_en;

  always_comb begin
    if (!free_run_i && (cnt_q == cmp_i)) nxt = '0;
    else                                 nxt = cnt_q + CNT_W'(1);
  end

  always_comb begin
    cnt_en    = 1'b0;
    cnt_d     = cnt_q;
    hit_cmp_o = 1'b0;
    hit_rov_o = 1'b0;
    if (clr_i) begin
      cnt_en = 1'b1;
      cnt_d  = '0;
    end else if (step_i) begin
      cnt_en    = 1'b1;
      cnt_d     = nxt;
      hit_cmp_o = (nxt == cmp_i);
      hit_rov_o = free_run_i && (&cnt_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/cmp_rollover_timer.sv
module cmp_rollover_timer #(
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12,
  parameter int IEN_W  = 6,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph_tick,
  input  logic              slow_tick,
  input  logic              reg_wen,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import cmpt_pkg::*;

  localparam logic [DATA_W-1:0] CTRL_STORE = ~(DATA_W'(32'h0000_FC00));
  localparam logic [DATA_W-1:0] SWR_DROP   =
    DATA_W'((1 << CB_EN) | (1 << CB_DBG) | (1 << CB_WAIT) | (1 << CB_DOZE));

  logic rst_i_n;

  logic [DATA_W-1:0] ctrl_q, ctrl_d;
  logic [PRE_W-1:0]  presc_q, presc_d;
  logic [IEN_W-1:0]  ien_q, ien_d;
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic [1:0]        st_q, st_d;
  logic ctrl_en, presc_en, ien_en, cmp_en, st_en;

  logic wr_ctrl, wr_presc, wr_stat, wr_ien, wr_cmp;
  logic swr, en_rise, cnt_clr;
  logic step;
  logic hit_cmp, hit_rov;
  logic [CNT_W-1:0] count;
  logic [1:0] w1c;

  cmpt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  assign wr_ctrl  = reg_wen && (reg_addr == ADDR_W'(IDX_CTRL));
  assign wr_presc = reg_wen && (reg_addr == ADDR_W'(IDX_PRESC));
  assign wr_stat  = reg_wen && (reg_addr == ADDR_W'(IDX_STAT));
  assign wr_ien   = reg_wen && (reg_addr == ADDR_W'(IDX_IEN));
  assign wr_cmp   = reg_wen && (reg_addr == ADDR_W'(IDX_CMP));

  assign swr     = wr_ctrl && reg_wdata[CB_SWRST];
  assign en_rise = wr_ctrl && !swr && reg_wdata[CB_EN] && !ctrl_q[CB_EN];
  assign cnt_clr = swr || (en_rise && reg_wdata[CB_ENCLR])
                 || (wr_cmp && !ctrl_q[CB_FREE]);

  // next-state for the register file
  always_comb begin
    ctrl_en = wr_ctrl;
    ctrl_d  = reg_wdata & CTRL_STORE;
    if (swr) ctrl_d = ctrl_d & ~SWR_DROP;

    presc_en = wr_presc || swr;
    presc_d  = swr ? '0 : reg_wdata[PRE_W-1:0];

    ien_en = wr_ien || swr;
    ien_d  = swr ? '0 : reg_wdata[IEN_W-1:0];

    cmp_en = wr_cmp || swr;
    cmp_d  = swr ? '1 : reg_wdata[CNT_W-1:0];

    w1c   = wr_stat ? {reg_wdata[SB_ROV], reg_wdata[SB_CMP]} : 2'b00;
    st_en = swr || wr_stat || hit_cmp || hit_rov;
    st_d  = swr ? 2'b00 : ((st_q & ~w1c) | {hit_rov, hit_cmp});
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      ctrl_q  <= '0;
      presc_q <= '0;
      ien_q   <= '0;
      cmp_q   <= '1;
      st_q    <= '0;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (presc_en) presc_q <= presc_d;
      if (ien_en)   ien_q   <= ien_d;
      if (cmp_en)   cmp_q   <= cmp_d;
      if (st_en)    st_q    <= st_d;
    end
  end

  cmpt_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk         (clk),
    .rst_n       (rst_i_n),
    .run_i       (ctrl_q[CB_EN]),
    .phase_clr_i (cnt_clr),
    .src_sel_i   (ctrl_q[CB_SRC_HI:CB_SRC_LO]),
    .fast_tick_i (periph_tick),
    .slow_tick_i (slow_tick),
    .presc_i     (presc_q),
    .step_o      (step)
  );

  cmpt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .step_i     (step),
    .clr_i      (cnt_clr),
    .free_run_i (ctrl_q[CB_FREE]),
    .cmp_i      (cmp_q),
    .count_o    (count),
    .hit_cmp_o  (hit_cmp),
    .hit_rov_o  (hit_rov)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(IDX_CTRL):  reg_rdata = ctrl_q;
      ADDR_W'(IDX_PRESC): reg_rdata[PRE_W-1:0] = presc_q;
      ADDR_W'(IDX_STAT): begin
        reg_rdata[SB_CMP] = st_q[0];
        reg_rdata[SB_ROV] = st_q[1];
      end
      ADDR_W'(IDX_IEN):   reg_rdata[IEN_W-1:0] = ien_q;
      ADDR_W'(IDX_CMP):   reg_rdata[CNT_W-1:0] = cmp_q;
      ADDR_W'(IDX_COUNT): reg_rdata[CNT_W-1:0] = count;
      default:            reg_rdata = '0;
    endcase
  end

  assign irq = ctrl_q[CB_EN] &&
               ((st_q[0] && ien_q[SB_CMP]) || (st_q[1] && ien_q[SB_ROV]));
endmodule

// File: rtl/cmp_rollover_timer_chk.sv
module cmp_rollover_timer_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wen,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic [DATA_W-1:0] ctrl_q,
  input logic [CNT_W-1:0]  cmp_q,
  input logic [CNT_W-1:0]  count,
  input logic [1:0]        st_q,
  input logic              step,
  input logic              cnt_clr,
  input logic              hit_cmp
);
  import cmpt_pkg::*;

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl_q[CB_EN]);

  // R11
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !cnt_clr) |=> $stable(count));

  // R7
  restart_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ctrl_q[CB_FREE] && (count == cmp_q)) |=> (count == '0));

  // R6
  rollover_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !cnt_clr && ctrl_q[CB_FREE] && (&count)) |=> st_q[1]);

  // R8
  w1c_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == ADDR_W'(IDX_STAT) && reg_wdata[SB_CMP] && !hit_cmp)
      |=> !st_q[0]);

  // R13
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wen && reg_addr == ADDR_W'(IDX_CTRL) && reg_wdata[CB_SWRST])
      |=> ((count == '0) && (&cmp_q) && !ctrl_q[CB_EN] && (st_q == 2'b00)));

  // R2
  ctrl_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(IDX_CTRL)) |-> (reg_rdata[15:10] == 6'd0));
endmodule

bind cmp_rollover_timer cmp_rollover_timer_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_i_n),
  .reg_wen   (reg_wen),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .irq       (irq),
  .ctrl_q    (ctrl_q),
  .cmp_q     (cmp_q),
  .count     (count),
  .st_q      (st_q),
  .step      (step),
  .cnt_clr   (cnt_clr),
  .hit_cmp   (hit_cmp)
);

// File: tb/test_cmp_rollover_timer.sv
`timescale 1ns/1ps
module test_cmp_rollover_timer;
  localparam int CW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        periph_tick, slow_tick;
  logic        reg_wen;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  always #2 clk = ~clk;

  cmp_rollover_timer #(.CNT_W(CW)) i_cmp_rollover_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .periph_tick (periph_tick),
    .slow_tick   (slow_tick),
    .reg_wen     (reg_wen),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .irq         (irq)
  );

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  logic chk_vld = 1'b0;
  bit   done = 1'b0;

  // monitor: pop one expectation per sampled check
  always @(negedge clk) begin
    if (chk_vld && sb_q.size() > 0) begin
      exp_t it;
      logic [31:0] act;
      it  = sb_q.pop_front();
      act = it.is_irq ? {31'd0, irq} : reg_rdata;
      n_checks++;
      if (act !== it.exp) begin
        n_errors++;
        $display("FAIL %s: actual=0x%08h expected=0x%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(posedge clk); #1;
    reg_wen = 1'b0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_t it;
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    chk_vld = 1'b1;
    @(posedge clk); #1;
    chk_vld = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    exp_t it;
    it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
    sb_q.push_back(it);
    chk_vld = 1'b1;
    @(posedge clk); #1;
    chk_vld = 1'b0;
  endtask

  task automatic ticks(input bit slow, input int n);
    if (slow) slow_tick = 1'b1; else periph_tick = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    slow_tick = 1'b0; periph_tick = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; periph_tick = 1'b0; slow_tick = 1'b0;
    reg_wen = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk); #1;

    // R1 reset state
    chk(0, 32'h0, "R1 ctrl");
    chk(1, 32'h0, "R1 presc");
    chk(2, 32'h0, "R1 status");
    chk(3, 32'h0, "R1 ien");
    chk(4, 32'hFF, "R1 cmp all-ones");
    chk(9, 32'h0, "R1 count");
    chk_irq(1'b0, "R1 irq");

    // R5 free-run compare
    wr(4, 32'd5);
    wr(0, 32'h241);
    ticks(0, 3);
    chk(9, 32'd3, "R5 count 3");
    chk(2, 32'h0, "R5 no flag yet");
    ticks(0, 2);
    chk(9, 32'd5, "R5 count at cmp");
    chk(2, 32'h1, "R5 flag set");
    ticks(0, 1);
    chk(9, 32'd6, "R5 counts past cmp");

    // R8 write-1-to-clear
    wr(2, 32'h0);
    chk(2, 32'h1, "R8 write 0 keeps");
    wr(2, 32'h20);
    chk(2, 32'h1, "R8 other bit keeps");
    wr(2, 32'h1);
    chk(2, 32'h0, "R8 write 1 clears");

    // R6 rollover
    ticks(0, 249);
    chk(9, 32'hFF, "R6 count at all-ones");
    chk(2, 32'h0, "R6 no flag before wrap");
    ticks(0, 1);
    chk(9, 32'h0, "R6 wrapped");
    chk(2, 32'h20, "R6 rollover flag");

    // R9 interrupt gating
    wr(3, 32'h20);
    chk_irq(1'b1, "R9 irq rov enabled");
    wr(3, 32'h01);
    chk_irq(1'b0, "R9 irq other enable");
    wr(3, 32'h20);
    wr(0, 32'h240);
    chk_irq(1'b0, "R9 irq disabled timer");
    wr(2, 32'h20);
    wr(3, 32'hFF);
    chk(3, 32'h3F, "R9 ien 6 bits");
    wr(3, 32'h0);

    // R7 restart mode, R12 compare write
    wr(0, 32'h040);
    wr(4, 32'd3);
    wr(0, 32'h041);
    ticks(0, 3);
    chk(9, 32'd3, "R7 reached cmp");
    chk(2, 32'h1, "R7 flag set");
    ticks(0, 1);
    chk(9, 32'd0, "R7 back to zero");
    ticks(0, 2);
    chk(9, 32'd2, "R7 counting again");
    wr(4, 32'd10);
    chk(9, 32'd0, "R12 cmp write clears");
    wr(2, 32'h1);

    // R11 hold, R10 enable mode
    ticks(0, 4);
    chk(9, 32'd4, "R10 before disable");
    wr(0, 32'h040);
    ticks(0, 3);
    chk(9, 32'd4, "R11 frozen while off");
    wr(0, 32'h041);
    chk(9, 32'd4, "R10 resume keeps count");
    ticks(0, 1);
    chk(9, 32'd5, "R10 resumed");
    wr(0, 32'h040);
    wr(0, 32'h043);
    chk(9, 32'd0, "R10 clear on enable");

    // R3 prescaler
    wr(0, 32'h040);
    wr(1, 32'd2);
    wr(0, 32'h043);
    ticks(0, 5);
    chk(9, 32'd1, "R3 one step in 5 ticks");
    ticks(0, 1);
    chk(9, 32'd2, "R3 step on 6th tick");
    wr(1, 32'h1FFF);
    chk(1, 32'hFFF, "R3 12-bit field");
    wr(1, 32'h0);

    // R4 source select
    wr(0, 32'h103);
    ticks(0, 3);
    chk(9, 32'd2, "R4 slow src ignores fast");
    ticks(1, 2);
    chk(9, 32'd4, "R4 slow src counts");
    wr(0, 32'h0C1);
    ticks(0, 2);
    ticks(1, 2);
    chk(9, 32'd4, "R4 code 011 stopped");
    wr(0, 32'h081);
    ticks(0, 1);
    chk(9, 32'd5, "R4 code 010 fast");

    // R2 control read-back
    wr(0, 32'hFFFF7FFF);
    chk(0, 32'hFFFF03FF, "R2 ctrl gap bits");
    chk(9, 32'd5, "R4 code 111 stopped");

    // R13 software reset
    wr(1, 32'd5);
    wr(3, 32'h21);
    wr(4, 32'd9);
    wr(0, 32'h243);
    ticks(0, 24);
    chk(9, 32'd9, "R13 setup count");
    chk_irq(1'b1, "R13 setup irq");
    wr(0, 32'hFFFFFFFF);
    chk(0, 32'hFFFF03E2, "R13 ctrl after swr");
    chk(2, 32'h0, "R13 status");
    chk(1, 32'h0, "R13 presc");
    chk(3, 32'h0, "R13 ien");
    chk(9, 32'h0, "R13 count");
    chk(4, 32'hFF, "R13 cmp");
    chk_irq(1'b0, "R13 irq");

    // R2 unmapped indices
    wr(7, 32'hDEADBEEF);
    chk(7, 32'h0, "R2 index 7");
    chk(5, 32'h0, "R2 index 5");
    chk(15, 32'h0, "R2 index 15");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule